// File: doc/BRIEF.md
# Masked One-Bit Cipher Feedback Sequencer

This block carries out one-bit cipher feedback over a single data byte. An 8-bit mask register picks which bit positions of the byte take part. After a start pulse the block visits the picked positions one at a time, in a scan order that can be programmed. For each position it asks an external cipher engine for one keystream bit, XORs that bit with the data bit, and writes the result into the same position of the output byte. The ciphertext bit is then shifted into the low end of a 64-bit feedback register. Output positions that the mask leaves out are filled with a programmable constant.

The engine sees the feedback register on its own port. It returns the keystream bit, which is the top bit of its cipher output for that register value, together with a valid strobe. The feedback register is loaded from an initialization-vector input. It keeps its contents from one byte to the next, so a stream of bytes forms one continuous feedback chain. The DES rounds are outside this block.

Top module: `cfb1_bit_sequencer`

## Requirements
- R1: The mask register resets to 0 and is read back on `maskOut`. A write (`maskWe` high with `maskIn`) is accepted only while `cfb1Mode` is 1. While `cfb1Mode` is 0 a write leaves `maskOut` unchanged. Bit i of the mask selects bit i of the byte.
- R2: For every position i whose mask bit is 1, exactly one keystream request is made, and output bit i becomes data bit i XOR the returned keystream bit. Positions whose mask bit is 0 cause no request and are never read into the feedback chain.
- R3: When `cfb1Mode` is 1 and `lsbFirst` is 1, the selected positions are visited from bit 0 upward. In every other case they are visited from bit 7 downward. `lsbFirst` has no effect while `cfb1Mode` is 0.
- R4: At the end of an operation, every output position whose mask bit was 0 equals `fillOne`, as sampled at start.
- R5: On each visited bit the feedback register shifts left by one. In encrypt mode (`encrypt` = 1) the new bit 0 is the output bit. In decrypt mode it is the incoming data bit.
- R6: `ksReq` stays high, and `ksFeed` stays unchanged, until the cycle in which `ksValid` is 1. `ksBit` is taken in that cycle.
- R7: With an all-zero mask, `done` is high in the cycle right after the start cycle, no request is made, and `dataOut` equals `fillOne` in every bit.
- R8: `ivLoad` copies `ivIn` into the feedback register only while `busy` is low. While busy it is ignored. Between operations the feedback register keeps its value.
- R9: `busy` is high from the cycle after start up to and including the `done` cycle. `done` lasts one cycle. `start` is ignored while busy. `dataOut` holds its value between operations.
- R10: After reset, `busy`, `done` and `ksReq` are low, and `dataOut`, `maskOut` and `ksFeed` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfb1Mode | input | 1 | 1 when the one-bit feedback mode is selected |
| maskWe | input | 1 | Mask register write enable |
| maskIn | input | 8 | Mask write data |
| maskOut | output | 8 | Mask register readback |
| lsbFirst | input | 1 | Scan direction: 1 = from bit 0 upward |
| fillOne | input | 1 | Value for masked-off output bits |
| encrypt | input | 1 | 1 = encrypt, 0 = decrypt |
| ivLoad | input | 1 | Load the feedback register from `ivIn` |
| ivIn | input | 64 | Initialization vector |
| dataIn | input | 8 | Data byte, sampled at start |
| start | input | 1 | Begin one byte operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dataOut | output | 8 | Result byte |
| ksReq | output | 1 | Keystream bit request |
| ksFeed | output | 64 | Feedback register presented to the engine |
| ksValid | input | 1 | Engine reply strobe |
| ksBit | input | 1 | Keystream bit returned by the engine |

## Verification
A wrong scan order or a wrong pending-bit vector shows on `ksFeed` within one engine handshake. The shifted-in bit comes from a different data position, and the register presented for the next request differs at once. A bad fill or XOR path shows on `dataOut` in the `done` cycle of the same byte. A stale feedback register shows on the first request of the next byte. A sequencing fault, such as a request made for a masked-off bit or a missed `done`, changes `ksReq`, `busy` or `done` in the cycle where the reference model expects the next phase.

// File: rtl/cfb1_seq_pkg.sv
package cfb1_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SCAN = 2'd1,
    SEQ_WAIT = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch byte, mask snapshot and options
    logic advance;  // consume one keystream bit
  } seqStrobe_t;

endpackage

// File: rtl/cfb1_seq_ctrl.sv
module cfb1_seq_ctrl
  import cfb1_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       ksValid,
  input  logic       pendEmpty,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       ksReq
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE: if (start)   stateNext = SEQ_SCAN;
      SEQ_SCAN: stateNext = pendEmpty ? SEQ_IDLE : SEQ_WAIT;
      SEQ_WAIT: if (ksValid) stateNext = SEQ_SCAN;
      default:  stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.capture = (state == SEQ_IDLE) && start;
    strb.advance = (state == SEQ_WAIT) && ksValid;
    busy  = (state != SEQ_IDLE);
    done  = (state == SEQ_SCAN) && pendEmpty;
    ksReq = (state == SEQ_WAIT);
  end

endmodule

// File: rtl/cfb1_seq_datapath.sv
module cfb1_seq_datapath
  import cfb1_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FB_W   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              busy,
  input  logic              cfb1Mode,
  input  logic              maskWe,
  input  logic [DATA_W-1:0] maskIn,
  input  logic              lsbFirst,
  input  logic              fillOne,
  input  logic              encrypt,
  input  logic              ivLoad,
  input  logic [FB_W-1:0]   ivIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ksBit,
  output logic              pendEmpty,
  output logic [DATA_W-1:0] maskReg,
  output logic [DATA_W-1:0] outReg,
  output logic [FB_W-1:0]   fbReg
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] pend;
  logic [DATA_W-1:0] dataLat;
  logic              encLat;
  logic              lsbLat;
  logic [IDX_W-1:0]  curIdx;
  logic              curData;
  logic              resBit;
  logic              fbIn;

  // next position: highest pending bit for MSB-first, lowest for LSB-first
  always_comb begin
    curIdx = '0;
    if (lsbLat) begin
      for (int i = DATA_W - 1; i >= 0; i--)
        if (pend[i]) curIdx = IDX_W'(i);
    end else begin
      for (int i = 0; i < DATA_W; i++)
        if (pend[i]) curIdx = IDX_W'(i);
    end
  end

  assign curData   = dataLat[curIdx];
  assign resBit    = curData ^ ksBit;
  assign fbIn      = encLat ? resBit : curData;
  assign pendEmpty = (pend == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      outReg  <= '0;
      fbReg   <= '0;
      pend    <= '0;
      dataLat <= '0;
      encLat  <= 1'b0;
      lsbLat  <= 1'b0;
    end else begin
      if (maskWe && cfb1Mode) maskReg <= maskIn;

      if (ivLoad && !busy)   fbReg <= ivIn;
      else if (strb.advance) fbReg <= {fbReg[FB_W-2:0], fbIn};

      if (strb.capture) begin
        pend    <= maskReg;
        dataLat <= dataIn;
        encLat  <= encrypt;
        lsbLat  <= cfb1Mode & lsbFirst;
        outReg  <= {DATA_W{fillOne}};
      end else if (strb.advance) begin
        pend[curIdx]   <= 1'b0;
        outReg[curIdx] <= resBit;
      end
    end
  end

endmodule

// File: rtl/cfb1_bit_sequencer.sv
module cfb1_bit_sequencer
  import cfb1_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FB_W   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfb1Mode,
  input  logic              maskWe,
  input  logic [DATA_W-1:0] maskIn,
  output logic [DATA_W-1:0] maskOut,
  input  logic              lsbFirst,
  input  logic              fillOne,
  input  logic              encrypt,
  input  logic              ivLoad,
  input  logic [FB_W-1:0]   ivIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] dataOut,
  output logic              ksReq,
  output logic [FB_W-1:0]   ksFeed,
  input  logic              ksValid,
  input  logic              ksBit
);

  seqStrobe_t strb;
  logic       pendEmpty;

  cfb1_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .ksValid   (ksValid),
    .pendEmpty (pendEmpty),
    .strb      (strb),
    .busy      (busy),
    .done      (done),
    .ksReq     (ksReq)
  );

  cfb1_seq_datapath #(.DATA_W(DATA_W), .FB_W(FB_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busy      (busy),
    .cfb1Mode  (cfb1Mode),
    .maskWe    (maskWe),
    .maskIn    (maskIn),
    .lsbFirst  (lsbFirst),
    .fillOne   (fillOne),
    .encrypt   (encrypt),
    .ivLoad    (ivLoad),
    .ivIn      (ivIn),
    .dataIn    (dataIn),
    .ksBit     (ksBit),
    .pendEmpty (pendEmpty),
    .maskReg   (maskOut),
    .outReg    (dataOut),
    .fbReg     (ksFeed)
  );

endmodule

// File: rtl/cfb1_seq_sva.sv
module cfb1_seq_sva #(
  parameter int DATA_W = 8,
  parameter int FB_W   = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfb1Mode,
  input logic [DATA_W-1:0] maskOut,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] dataOut,
  input logic              ksReq,
  input logic [FB_W-1:0]   ksFeed,
  input logic              ksValid
);

  a_r1_mask_locked: assert property (@(posedge clk) disable iff (!rstN)
    !cfb1Mode |=> $stable(maskOut));

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (ksReq && !ksValid) |=> ksReq);

  a_r6_feed_steady: assert property (@(posedge clk) disable iff (!rstN)
    (ksReq && !ksValid) |=> $stable(ksFeed));

  a_r7_empty_mask_done: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && maskOut == '0) |=> (done && !ksReq));

  a_r8_feed_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(ksReq && ksValid)) |=> $stable(ksFeed));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(dataOut));

endmodule

bind cfb1_bit_sequencer cfb1_seq_sva #(.DATA_W(DATA_W), .FB_W(FB_W)) u_sva (
  .clk      (clk),
  .rstN     (rstN),
  .cfb1Mode (cfb1Mode),
  .maskOut  (maskOut),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .dataOut  (dataOut),
  .ksReq    (ksReq),
  .ksFeed   (ksFeed),
  .ksValid  (ksValid)
);

// File: tb/tb_cfb1_bit_sequencer.sv
module tb_cfb1_bit_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfb1Mode = 1'b1, maskWe = 1'b0, lsbFirst = 1'b0;
  logic        fillOne = 1'b0, encrypt = 1'b1, ivLoad = 1'b0, start = 1'b0;
  logic [7:0]  maskIn = '0, dataIn = '0;
  logic [63:0] ivIn = '0;
  logic        ksValid = 1'b0, ksBit = 1'b0;
  logic [7:0]  maskOut, dataOut;
  logic [63:0] ksFeed;
  logic        busy, done, ksReq;

  always #5 clk = ~clk;

  cfb1_bit_sequencer dut (
    .clk(clk), .rstN(rstN), .cfb1Mode(cfb1Mode), .maskWe(maskWe),
    .maskIn(maskIn), .maskOut(maskOut), .lsbFirst(lsbFirst),
    .fillOne(fillOne), .encrypt(encrypt), .ivLoad(ivLoad), .ivIn(ivIn),
    .dataIn(dataIn), .start(start), .busy(busy), .done(done),
    .dataOut(dataOut), .ksReq(ksReq), .ksFeed(ksFeed),
    .ksValid(ksValid), .ksBit(ksBit)
  );

  int vectors = 0;
  int misses  = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int          mPhase = 0;   // 0 idle, 1 scan, 2 wait
  int          mQueue[$];
  logic [7:0]  mMask = '0, mOut = '0, mData = '0;
  logic [63:0] mFb = '0;
  logic        mEnc = 1'b0;
  bit          modelLive = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mQueue.delete(); mMask = '0; mOut = '0; mFb = '0;
      modelLive = 1;
    end else begin
      int  ph;
      logic [7:0] oldMask;
      ph = mPhase;
      oldMask = mMask;
      if (maskWe && cfb1Mode) mMask = maskIn;
      if (ivLoad && ph == 0) mFb = ivIn;
      if (ph == 0) begin
        if (start) begin
          mQueue.delete();
          if (cfb1Mode && lsbFirst) begin
            for (int i = 0; i < 8; i++) if (oldMask[i]) mQueue.push_back(i);
          end else begin
            for (int i = 7; i >= 0; i--) if (oldMask[i]) mQueue.push_back(i);
          end
          mOut = fillOne ? 8'hFF : 8'h00;
          mData = dataIn;
          mEnc = encrypt;
          mPhase = 1;
        end
      end else if (ph == 1) begin
        mPhase = (mQueue.size() == 0) ? 0 : 2;
      end else if (ksValid) begin
        int  idx;
        logic r;
        idx = mQueue.pop_front();
        r = mData[idx] ^ ksBit;
        mOut[idx] = r;
        mFb = {mFb[62:0], mEnc ? r : mData[idx]};
        mPhase = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (modelLive) begin
      chk("R9",  "busy",    64'(busy),  64'(mPhase != 0));
      chk("R9",  "done",    64'(done),  64'(mPhase == 1 && mQueue.size() == 0));
      chk("R6",  "ksReq",   64'(ksReq), 64'(mPhase == 2));
      chk("R2",  "dataOut", 64'(dataOut), 64'(mOut));
      chk("R5",  "ksFeed",  ksFeed, mFb);
      chk("R1",  "maskOut", 64'(maskOut), 64'(mMask));
    end
  end

  // ---------------- engine model ----------------
  int engLat = 0;
  int engWait = 0;
  int reqCnt = 0;
  int keyTurn = 0;
  localparam logic [63:0] KEY = 64'hC3A5_9617_E24B_5D08;

  always @(negedge clk) begin
    if (ksReq) begin
      if (engWait == engLat) begin
        ksValid = 1'b1;
        ksBit   = (^(ksFeed & KEY)) ^ keyTurn[0];
        keyTurn++;
        reqCnt++;
      end else begin
        ksValid = 1'b0;
      end
      engWait++;
    end else begin
      ksValid = 1'b0;
      engWait = 0;
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] curMask = '0;

  task automatic writeMask(input logic [7:0] m, input logic mode);
    cfb1Mode = mode; maskIn = m; maskWe = 1'b1;
    @(negedge clk);
    maskWe = 1'b0; cfb1Mode = 1'b1;
  endtask

  task automatic loadIv(input logic [63:0] v);
    ivIn = v; ivLoad = 1'b1;
    @(negedge clk);
    ivLoad = 1'b0;
  endtask

  task automatic runOp(input logic [7:0] d, input logic enc, input logic lsb,
                       input logic fill, input logic mode, input int lat,
                       input bit poke);
    int cyc;
    logic [7:0] expFill;
    cfb1Mode = mode; dataIn = d; encrypt = enc; lsbFirst = lsb;
    fillOne = fill; engLat = lat; reqCnt = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      if (poke && cyc == 2) begin
        // R8 / R9: iv load and start while busy must be ignored
        ivIn = ~ksFeed; ivLoad = 1'b1; start = 1'b1; dataIn = ~d;
      end else begin
        ivLoad = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    ivLoad = 1'b0; start = 1'b0;
    chk("R9", "done reached", 64'(done), 64'd1);
    chk("R2", "request count", 64'(reqCnt), 64'($countones(curMask)));
    expFill = fill ? ~curMask : 8'h00;
    chk("R4", "masked-off fill", 64'(dataOut & ~curMask), 64'(expFill));
    @(negedge clk);
    chk("R9", "done single cycle", 64'(done), 64'd0);
    cfb1Mode = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "reset busy",    64'(busy),    64'd0);
    chk("R10", "reset done",    64'(done),    64'd0);
    chk("R10", "reset ksReq",   64'(ksReq),   64'd0);
    chk("R10", "reset dataOut", 64'(dataOut), 64'd0);
    chk("R10", "reset maskOut", 64'(maskOut), 64'd0);
    chk("R10", "reset ksFeed",  ksFeed,       64'd0);

    // R1 mask write blocked outside the one-bit mode
    writeMask(8'h3C, 1'b0);
    chk("R1", "mask write outside mode", 64'(maskOut), 64'd0);
    writeMask(8'hA5, 1'b1); curMask = 8'hA5;
    chk("R1", "mask write in mode", 64'(maskOut), 64'hA5);

    // R8 iv load when idle
    loadIv(64'h0123_4567_89AB_CDEF);
    chk("R8", "iv loaded", ksFeed, 64'h0123_4567_89AB_CDEF);

    // R2 R3 R5: encrypt, MSB-first, immediate engine
    runOp(8'h96, 1'b1, 1'b0, 1'b0, 1'b1, 0, 0);
    chk("R5", "feedback after msb byte", ksFeed, mFb);
    // R3 LSB-first with slow engine, fill ones
    writeMask(8'h3C, 1'b1); curMask = 8'h3C;
    runOp(8'h5A, 1'b1, 1'b1, 1'b1, 1'b1, 2, 0);
    chk("R3", "feedback after lsb byte", ksFeed, mFb);
    // R5 decrypt, full mask
    writeMask(8'hFF, 1'b1); curMask = 8'hFF;
    runOp(8'hE1, 1'b0, 1'b0, 1'b0, 1'b1, 1, 0);
    chk("R5", "decrypt feedback", ksFeed, mFb);

    // R7 empty mask
    writeMask(8'h00, 1'b1); curMask = 8'h00;
    reqCnt = 0; fillOne = 1'b1; dataIn = 8'h42; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "done next cycle", 64'(done), 64'd1);
    chk("R7", "fill all bits", 64'(dataOut), 64'hFF);
    @(negedge clk);
    chk("R7", "no request", 64'(reqCnt), 64'd0);

    // R3 direction ignored outside mode; R8/R9 pokes while busy
    writeMask(8'h81, 1'b1); curMask = 8'h81;
    runOp(8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1);
    chk("R3", "msb order outside mode", ksFeed, mFb);
    chk("R8", "iv ignored while busy", ksFeed, mFb);

    // mixed stream, R8 feedback kept across bytes
    for (int k = 0; k < 24; k++) begin
      logic [7:0] m;
      m = 8'(k * 37 + 11);
      writeMask(m, 1'b1); curMask = m;
      runOp(8'(k * 91 + 5), k[0], k[1], k[2], ~(k[3] & k[1]), k % 3, k[2]);
    end
    chk("R8", "feedback chain kept", ksFeed, mFb);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule